// File: doc/BRIEF.md
# ECC Read-Modify-Write Memory Front End

This block sits between a single bus initiator and a 32-bit word memory that keeps a 7-bit error-correcting code in the same location as each data word. Every read passes through a SECDED decoder. A single flipped bit is repaired before the data goes back, and an error that cannot be repaired is flagged in the response. A plain read never writes anything back to memory.

A write that covers all four byte lanes is encoded and stored in one memory access. A write that covers only some lanes is turned into a sequence: read the old word, repair it if needed, merge in the new lanes, re-encode and write back. The code therefore always covers the full word. If the old word holds an uncorrectable error, the write-back is abandoned and the failure is reported.

An enable input can switch the code off. In that mode words are stored and returned raw, and byte enables go straight to the memory. Sticky status bits record that an error was seen and the address of the first failing word since the last clear.

Top module: `ecc_rmw_front`

## Requirements
- R1: The stored word is 39 bits wide. Bits [31:0] hold the data. Bits [37:32] are Hamming parity bits for codeword positions 1, 2, 4, 8, 16 and 32, where data bits 0..31 fill the remaining positions 3..38 in ascending order. Bit 38 is even parity over the other 38 bits.
- R2: On a read with the code enabled, any single flipped bit among the 39 stored bits gives the original data, with rsp_corr=1 and rsp_fail=0.
- R3: On a read with the code enabled, two flipped bits give rsp_fail=1 and rsp_corr=0.
- R4: A read request causes exactly one memory read and no memory write, even when it repairs an error.
- R5: A write with the code enabled and not all of req_be set performs one read and then one write of the enclosing word. Only lanes whose req_be bit is set (lane n = bits 8n+7..8n) are replaced, and the old word is repaired before merging. The response comes 4 cycles after acceptance.
- R6: If that read finds an uncorrectable error, nothing is written, the response has rsp_fail=1, and the response comes 3 cycles after acceptance.
- R7: A write with all four req_be bits set performs one memory write and no read. The response comes 2 cycles after acceptance, and mem_wbe=5'b11111.
- R8: req_ready is high only when the block is idle and low from the cycle after acceptance through the response cycle. A read responds 3 cycles after acceptance.
- R9: stat_sbe and stat_dbe are set by correctable and uncorrectable errors found with the code enabled. stat_addr holds the word address of the first error since the last clear. stat_clr clears both bits and takes priority.
- R10: With ecc_en low, reads return raw bits [31:0] with no flags and no status. Any write is a single access with mem_wbe[3:0]=req_be and mem_wbe[4]=0 (check field untouched), responding after 2 cycles.
- R11: Every request gets exactly one single-cycle rsp_valid pulse, and rsp_rdata is zero for write responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_en | input | 1 | Enables check code generation and checking |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte lane enables |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_corr | output | 1 | A single-bit error was repaired |
| rsp_fail | output | 1 | Uncorrectable error; write aborted |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wbe | output | 5 | Write enables: [3:0] data lanes, [4] check field |
| mem_wdata | output | 39 | Stored word to write |
| mem_rdata | input | 39 | Stored word, one cycle after a read strobe |
| stat_clr | input | 1 | Clears sticky status |
| stat_sbe | output | 1 | Sticky correctable-error flag |
| stat_dbe | output | 1 | Sticky uncorrectable-error flag |
| stat_addr | output | ADDR_W | Address of first error since clear |

## Verification
The bench flips each of the 39 stored bits of one word in turn. A wrong parity-position mapping would then return bad data for some bit, or miss the flip of the overall parity bit. Double flips must be reported rather than "repaired" into a third wrong bit. The partial-write cases check two things: that a flip in a lane that is kept is repaired before the merge, so the later read is clean, and that an old word with a double error leaves memory untouched, where a faulty design would store a fresh code over bad data. Bypass mode checks that raw bits come back and that the check field is left alone on lane writes.

// File: rtl/ecc_pkg.sv
// Shared definitions for the ECC front end: code widths, controller states
// and the SECDED helper functions. Assumes a fixed 32-bit data word.
package ecc_pkg;

    localparam int DATA_W  = 32;
    localparam int HAM_W   = 6;
    localparam int CHK_W   = HAM_W + 1;
    localparam int CODE_W  = DATA_W + CHK_W;
    localparam int LANES   = DATA_W / 8;
    localparam int LAST_POS = DATA_W + HAM_W;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_MERGE = 3'd2,
        ST_WRITE = 3'd3,
        ST_RESP  = 3'd4
    } ctrl_st_t;

    // Hamming parity bits: parity j covers positions with bit j set.
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        int k;
        h = '0;
        k = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            logic [HAM_W-1:0] pv;
            pv = p[HAM_W-1:0];
            if ((pv & (pv - 1'b1)) != '0) begin
                for (int j = 0; j < HAM_W; j++)
                    if (pv[j]) h[j] = h[j] ^ d[k];
                k++;
            end
        end
        return h;
    endfunction

    // Data-bit mask that a syndrome points at (zero for parity positions).
    function automatic logic [DATA_W-1:0] flip_mask(input logic [HAM_W-1:0] s);
        logic [DATA_W-1:0] m;
        int k;
        m = '0;
        k = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            logic [HAM_W-1:0] pv;
            pv = p[HAM_W-1:0];
            if ((pv & (pv - 1'b1)) != '0) begin
                if (pv == s) m[k] = 1'b1;
                k++;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
// SECDED encoder: builds the 39-bit stored word {overall parity, Hamming
// bits, data}. Purely combinational.
module ecc_encoder
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);
    logic [HAM_W-1:0] ham;

    // Compute Hamming bits and overall even parity.
    always_comb begin
        ham    = ham_bits(data_i);
        code_o = {^{ham, data_i}, ham, data_i};
    end
endmodule

// File: rtl/ecc_decoder.sv
// SECDED decoder: classifies a stored word and repairs one flipped bit.
// Assumes the layout produced by ecc_encoder. Combinational.
module ecc_decoder
    import ecc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);
    logic [HAM_W-1:0] syn;
    logic             par_odd;
    logic             in_range;

    // Syndrome, parity and classification.
    always_comb begin
        syn      = ham_bits(code_i[DATA_W-1:0]) ^ code_i[DATA_W+HAM_W-1:DATA_W];
        par_odd  = ^code_i;
        in_range = (32'(syn) <= LAST_POS);
        single_o = par_odd && in_range;
        double_o = (!par_odd && syn != '0) || (par_odd && !in_range);
        data_o   = code_i[DATA_W-1:0] ^
                   ((par_odd && in_range) ? flip_mask(syn) : '0);
    end
endmodule

// File: rtl/ecc_lane_merge.sv
// Byte-lane merge: takes enabled lanes from the new word and the rest from
// the old word. One mux per lane.
module ecc_lane_merge
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [LANES-1:0]  be_i,
    output logic [DATA_W-1:0] merged_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Select the source of lane l.
        assign merged_o[8*l +: 8] = be_i[l] ? new_i[8*l +: 8] : old_i[8*l +: 8];
    end
endmodule

// File: rtl/ecc_err_status.sv
// Sticky error status: flags for correctable and uncorrectable errors plus
// the address of the first error since the last clear. Clear wins.
module ecc_err_status #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ev_single_i,
    input  logic              ev_double_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    output logic              sbe_o,
    output logic              dbe_o,
    output logic [ADDR_W-1:0] addr_o
);
    // Update the sticky flags and the captured address.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sbe_o  <= 1'b0;
            dbe_o  <= 1'b0;
            addr_o <= '0;
        end else begin
            if (ev_single_i) sbe_o <= 1'b1;
            if (ev_double_i) dbe_o <= 1'b1;
            if ((ev_single_i || ev_double_i) && !sbe_o && !dbe_o)
                addr_o <= ev_addr_i;
        end
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!sbe_o && !dbe_o)); // R9
endmodule

// File: rtl/ecc_rmw_front.sv
// ECC front end for a 32-bit word memory. Handles one request at a time:
// reads are checked and repaired, full writes are encoded directly, and
// partial writes run read / repair / merge / re-encode / write-back.
// Assumes the memory returns read data one cycle after mem_en with !mem_we.
module ecc_rmw_front
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_corr,
    output logic              rsp_fail,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES:0]    mem_wbe,
    output logic [CODE_W-1:0] mem_wdata,
    input  logic [CODE_W-1:0] mem_rdata,
    input  logic              stat_clr,
    output logic              stat_sbe,
    output logic              stat_dbe,
    output logic [ADDR_W-1:0] stat_addr
);
    ctrl_st_t          state;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic [DATA_W-1:0] r_word;
    logic [LANES-1:0]  r_be;
    logic              r_write;
    logic              r_ecc;
    logic              r_corr;
    logic              r_fail;

    logic              accept;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;
    logic [DATA_W-1:0] old_word;
    logic              ev_single;
    logic              ev_double;
    logic [DATA_W-1:0] merged;

    ecc_decoder i_dec (
        .code_i   (mem_rdata),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    ecc_lane_merge i_merge (
        .old_i    (old_word),
        .new_i    (r_wdata),
        .be_i     (r_be),
        .merged_o (merged)
    );

    ecc_encoder i_enc (
        .data_i (r_word),
        .code_o (mem_wdata)
    );

    ecc_err_status #(.ADDR_W(ADDR_W)) i_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (stat_clr),
        .ev_single_i (ev_single),
        .ev_double_i (ev_double),
        .ev_addr_i   (r_addr),
        .sbe_o       (stat_sbe),
        .dbe_o       (stat_dbe),
        .addr_o      (stat_addr)
    );

    // Select checked or raw old word and qualify error events.
    always_comb begin
        accept    = req_valid && req_ready;
        old_word  = r_ecc ? dec_data : mem_rdata[DATA_W-1:0];
        ev_single = (state == ST_MERGE) && r_ecc && dec_single;
        ev_double = (state == ST_MERGE) && r_ecc && dec_double;
    end

    // Controller state and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            r_addr  <= '0;
            r_wdata <= '0;
            r_word  <= '0;
            r_be    <= '0;
            r_write <= 1'b0;
            r_ecc   <= 1'b0;
            r_corr  <= 1'b0;
            r_fail  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    r_addr  <= req_addr;
                    r_wdata <= req_wdata;
                    r_word  <= req_wdata;
                    r_be    <= req_be;
                    r_write <= req_write;
                    r_ecc   <= ecc_en;
                    r_corr  <= 1'b0;
                    r_fail  <= 1'b0;
                    if (req_write && (!ecc_en || (&req_be)))
                        state <= ST_WRITE;
                    else
                        state <= ST_READ;
                end
                ST_READ:  state <= ST_MERGE;
                ST_MERGE: begin
                    r_corr <= ev_single;
                    if (!r_write) begin
                        r_word <= old_word;
                        r_fail <= ev_double;
                        state  <= ST_RESP;
                    end else if (ev_double) begin
                        r_fail <= 1'b1;
                        state  <= ST_RESP;
                    end else begin
                        r_word <= merged;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: state <= ST_RESP;
                ST_RESP:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_en    = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = r_addr;
        mem_wbe   = r_ecc ? {1'b1, {LANES{1'b1}}} : {1'b0, r_be};
        rsp_valid = (state == ST_RESP);
        rsp_rdata = r_write ? '0 : r_word;
        rsp_corr  = r_corr;
        rsp_fail  = r_fail;
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11
    AST_FAIL_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fail) |-> !$past(mem_we)); // R6
    AST_FULL_WRITE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && (!ecc_en || (&req_be)))
        |=> (mem_en && mem_we)); // R7
    AST_READ_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !r_write) |-> !$past(mem_we)); // R4
endmodule

// File: tb/test_ecc_rmw_front.sv
module test_ecc_rmw_front;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_corr, rsp_fail;
    logic        mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [4:0]  mem_wbe;
    logic [38:0] mem_wdata;
    logic [38:0] mem_rdata = '0;
    logic        stat_clr = 1'b0;
    logic        stat_sbe, stat_dbe;
    logic [AW-1:0] stat_addr;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [38:0] mem [64];
    logic [31:0] ref_data [64];

    logic [31:0] t_rd;
    logic        t_corr, t_fail;
    int          t_lat, t_nrd, t_nwr;

    always #10 clk = ~clk;

    ecc_rmw_front #(.ADDR_W(AW)) i_ecc_rmw_front (
        .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_corr(rsp_corr),
        .rsp_fail(rsp_fail), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wbe(mem_wbe), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .stat_clr(stat_clr), .stat_sbe(stat_sbe),
        .stat_dbe(stat_dbe), .stat_addr(stat_addr)
    );

    // Behavioural memory with one-cycle read latency and lane enables.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                wr_cnt++;
                for (int l = 0; l < 4; l++)
                    if (mem_wbe[l]) mem[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
                if (mem_wbe[4]) mem[mem_addr][38:32] <= mem_wdata[38:32];
            end else begin
                rd_cnt++;
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference stored word built from the R1 layout.
    function automatic logic [38:0] ref_code(input logic [31:0] d);
        logic [38:1] cw;
        logic [5:0]  h;
        int k;
        cw = '0; h = '0; k = 0;
        for (int p = 1; p <= 38; p++)
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
                cw[p] = d[k];
                k++;
            end
        for (int j = 0; j < 6; j++)
            for (int p = 1; p <= 38; p++)
                if ((p >> j) & 1) h[j] = h[j] ^ cw[p];
        return {^{h, d}, h, d};
    endfunction

    function automatic logic [31:0] ref_merge(input logic [31:0] o, input logic [31:0] n,
                                              input logic [3:0] be);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[8*l +: 8] = be[l] ? n[8*l +: 8] : o[8*l +: 8];
        return r;
    endfunction

    // One request; compares ready/valid every cycle and records the response.
    task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [3:0] be);
        int r0, w0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R8 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        t_lat = 1;
        while (!rsp_valid && t_lat < 10) begin
            if (req_ready !== 1'b0) chk(0, "R8 ready low while busy", req_ready, 0);
            @(negedge clk);
            t_lat++;
        end
        chk(req_ready === 1'b0, "R8 ready low in response cycle", req_ready, 0);
        t_rd = rsp_rdata; t_corr = rsp_corr; t_fail = rsp_fail;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11 single response pulse", rsp_valid, 0);
        t_nrd = rd_cnt - r0; t_nwr = wr_cnt - w0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [38:0] saved;
        for (int i = 0; i < 64; i++) begin mem[i] = '0; ref_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(req_ready === 1'b1, "R8 reset ready", req_ready, 1);
        chk(rsp_valid === 1'b0, "R11 reset no response", rsp_valid, 0);
        chk(mem_en === 1'b0, "R4 reset no access", mem_en, 0);
        chk(stat_sbe === 1'b0 && stat_dbe === 1'b0, "R9 reset status", {stat_sbe, stat_dbe}, 0);

        // R7 full writes, R8/R4 reads back
        for (int a = 0; a < 8; a++) begin
            logic [31:0] v;
            v = 32'h1357_9BDF * (a + 3) ^ 32'hA5A5_0F0F;
            do_req(1, a[AW-1:0], v, 4'hF);
            ref_data[a] = v;
            chk(t_lat == 2, "R7 full write latency", t_lat, 2);
            chk(t_nrd == 0 && t_nwr == 1, "R7 single write access", {t_nrd[7:0], t_nwr[7:0]}, 16'h0001);
            chk(t_rd == 0, "R11 write response data zero", t_rd, 0);
        end
        for (int a = 0; a < 8; a++) begin
            do_req(0, a[AW-1:0], 0, 4'h0);
            chk(t_rd == ref_data[a], "R8 read data", t_rd, ref_data[a]);
            chk(t_lat == 3, "R8 read latency", t_lat, 3);
            chk(t_nrd == 1 && t_nwr == 0, "R4 read one access", {t_nrd[7:0], t_nwr[7:0]}, 16'h0100);
            chk(!t_corr && !t_fail, "R2 clean read flags", {t_corr, t_fail}, 0);
        end
        // R1 layout
        chk(mem[1] == ref_code(ref_data[1]), "R1 stored layout", mem[1], ref_code(ref_data[1]));
        chk(mem[5] == ref_code(ref_data[5]), "R1 stored layout", mem[5], ref_code(ref_data[5]));

        // R2 every single flip, R4 no write-back
        for (int b = 0; b < 39; b++) begin
            saved = mem[2];
            mem[2][b] = ~mem[2][b];
            do_req(0, 2, 0, 4'h0);
            chk(t_rd == ref_data[2], "R2 corrected data", t_rd, ref_data[2]);
            chk(t_corr && !t_fail, "R2 corrected flag", {t_corr, t_fail}, 2'b10);
            chk(t_nwr == 0 && mem[2] != saved, "R4 no scrub write", t_nwr, 0);
            mem[2] = saved;
        end
        chk(stat_sbe && !stat_dbe && stat_addr == 2, "R9 sticky single and addr",
            {stat_sbe, stat_dbe, stat_addr}, {2'b10, 6'd2});

        // R3 double flips
        for (int k = 0; k < 3; k++) begin
            int b1, b2;
            b1 = (k == 0) ? 3 : (k == 1) ? 0 : 33;
            b2 = (k == 0) ? 17 : (k == 1) ? 35 : 38;
            saved = mem[3];
            mem[3][b1] = ~mem[3][b1];
            mem[3][b2] = ~mem[3][b2];
            do_req(0, 3, 0, 4'h0);
            chk(t_fail && !t_corr, "R3 double detected", {t_corr, t_fail}, 2'b01);
            mem[3] = saved;
        end
        chk(stat_dbe && stat_addr == 2, "R9 first address kept", {stat_dbe, stat_addr}, {1'b1, 6'd2});
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
        chk(!stat_sbe && !stat_dbe, "R9 clear", {stat_sbe, stat_dbe}, 0);

        // R5 partial writes
        do_req(1, 3, 32'hDEAD_BEEF, 4'b0010);
        ref_data[3] = ref_merge(ref_data[3], 32'hDEAD_BEEF, 4'b0010);
        chk(t_lat == 4, "R5 rmw latency", t_lat, 4);
        chk(t_nrd == 1 && t_nwr == 1, "R5 read then write", {t_nrd[7:0], t_nwr[7:0]}, 16'h0101);
        chk(mem[3] == ref_code(ref_data[3]), "R5 merged word re-encoded", mem[3], ref_code(ref_data[3]));
        do_req(1, 4, 32'h1234_5678, 4'b1100);
        ref_data[4] = ref_merge(ref_data[4], 32'h1234_5678, 4'b1100);
        do_req(0, 4, 0, 4'h0);
        chk(t_rd == ref_data[4] && !t_corr, "R5 half-word merge", t_rd, ref_data[4]);
        mem[4][20] = ~mem[4][20];
        do_req(1, 4, 32'h0000_00C3, 4'b0001);
        ref_data[4] = ref_merge(ref_data[4], 32'h0000_00C3, 4'b0001);
        chk(t_corr && !t_fail && t_lat == 4, "R5 repair before merge", {t_corr, t_fail}, 2'b10);
        do_req(0, 4, 0, 4'h0);
        chk(t_rd == ref_data[4] && !t_corr, "R5 repaired lane kept", t_rd, ref_data[4]);

        // R6 double error aborts write-back
        mem[5][1] = ~mem[5][1];
        mem[5][30] = ~mem[5][30];
        saved = mem[5];
        do_req(1, 5, 32'hFFFF_FFFF, 4'b0100);
        chk(t_fail && t_lat == 3, "R6 abort flagged", {t_fail, t_lat[7:0]}, {1'b1, 8'd3});
        chk(t_nwr == 0 && mem[5] == saved, "R6 memory unchanged", mem[5], saved);
        chk(stat_dbe, "R9 dbe from rmw", stat_dbe, 1);
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;

        // R10 bypass
        ecc_en = 1'b0;
        mem[6][7] = ~mem[6][7];
        do_req(0, 6, 0, 4'h0);
        chk(t_rd == (ref_data[6] ^ 32'h80) && !t_corr && !t_fail, "R10 raw read", t_rd, ref_data[6] ^ 32'h80);
        chk(!stat_sbe && !stat_dbe, "R10 no status in bypass", {stat_sbe, stat_dbe}, 0);
        saved = mem[7];
        do_req(1, 7, 32'hAABB_CCDD, 4'b0101);
        chk(t_lat == 2 && t_nrd == 0, "R10 direct lane write", t_lat, 2);
        chk(mem[7] == {saved[38:32], ref_merge(saved[31:0], 32'hAABB_CCDD, 4'b0101)},
            "R10 lanes and check field", mem[7],
            {saved[38:32], ref_merge(saved[31:0], 32'hAABB_CCDD, 4'b0101)});
        chk(t_rd == 0, "R11 write response data zero", t_rd, 0);
        ecc_en = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule